// File: doc/BRIEF.md
# Serial Debug Port Frame Engine

This block is the receive and transmit framing logic of a synchronous serial debug port that sits beside a processor core. An external debugger drives a serial clock and a data-in line; the block oversamples both with the core clock, finds the rising and falling serial clock edges, and splits the bit stream into frames. A frame opens with a low start bit. A control bit and a length bit follow it, and then the payload, which is either long (an opcode word) or short (a breakpoint-control word). The length bit alone sets the payload size.

A long instruction frame loads an opcode into the injection register and sends a single-cycle strobe to the core, as long as the core reports that it is in debug mode. While that long payload shifts in, a word captured from the core's debug data register shifts out on data-out, so each transfer is a full-duplex exchange. A short breakpoint frame updates the breakpoint-control bits and does not touch the core. A busy output covers each frame and each injected opcode until the core reports completion. A sticky error flag records frames that were ignored or could not be acted on.

Top module: `dbg_frame_port`

## Requirements
- R1: While and after synchronous reset, `dout` is 1, `busy` is 0, `frame_err` is 0, `bkpt_ctrl` is 0 and `inject_valid` is 0.
- R2: Serial bits are sampled on rising `sck` edges. While idle, a 0 on `din` is the start bit, the next bit is the control bit, the one after it is the length bit, and then the payload follows with its most significant bit first. Length bit 1 gives a 32-bit payload and length bit 0 gives a 7-bit payload.
- R3: A frame with control 0 and length 1, received while `core_in_debug` is 1 at its last bit, puts the payload on `inject_opcode` and raises `inject_valid` for exactly one clock cycle.
- R4: In an accepted long frame, `core_data` is captured when the length bit is sampled. Its bit 31-i is on `dout` at the rising `sck` edge of payload bit i, and `dout` changes only after falling `sck` edges.
- R5: `dout` is 1 outside the payload of an accepted long frame. Once the last payload bit has been sampled, it returns to 1.
- R6: A frame with control 1 and length 0 loads its 7-bit payload into `bkpt_ctrl` and gives no strobe. No other event changes `bkpt_ctrl` except reset.
- R7: `busy` is 1 from the start bit to the end of the frame. After an injection it stays 1 until `core_done` is seen.
- R8: A frame whose start bit arrives while an injected opcode is still pending is ignored: no strobe, no `bkpt_ctrl` change, `dout` stays 1, and `frame_err` is set.
- R9: An instruction frame that ends while `core_in_debug` is 0 gives no strobe and sets `frame_err`.
- R10: The combinations control 0 with length 0 (7-bit payload) and control 1 with length 1 (32-bit payload, `dout` still sends `core_data`) have no effect other than setting `frame_err`.
- R11: `frame_err` stays set until reset. A reset in the middle of a frame drops the partial frame, so the next full frame is received correctly.
- R12: A rising `sck` edge while idle with `din` at 1 does not start a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock that oversamples the serial lines |
| rst | input | 1 | Synchronous reset, active high |
| sck | input | 1 | Serial clock from the debugger, idle low |
| din | input | 1 | Serial data from the debugger, idle high |
| dout | output | 1 | Serial data to the debugger, idle high |
| core_in_debug | input | 1 | Core is in debug mode and accepts opcodes |
| core_done | input | 1 | Core has finished the injected opcode (one-cycle pulse) |
| core_data | input | 32 | Debug data register contents to send |
| inject_opcode | output | 32 | Last injected opcode |
| inject_valid | output | 1 | One-cycle strobe: execute `inject_opcode` |
| bkpt_ctrl | output | 7 | Breakpoint-control bits |
| busy | output | 1 | Frame in progress or opcode pending |
| frame_err | output | 1 | Sticky error flag |

## Verification
The bench sweeps every one of the 128 breakpoint words and walks a single one through all 32 opcode bit positions. Each opcode is paired with a distinct `core_data` word, so a byte or bit reversal, an off-by-one payload count or a wrong length decode shows up as a wrong opcode, a wrong captured word or a shifted `dout` stream. The error paths come next: a frame during a pending opcode, an injection outside debug mode, both mismatched control/length pairs, and a reset in mid-frame. A design that wrongly accepts one of these would pulse the strobe or change the breakpoint bits. A design that does not clear its counter would misframe the next transfer. A high `din` on a rising edge while idle must not open a frame; if it did, the frame that follows would come out misaligned.

// File: rtl/dbgp_pkg.sv
package dbgp_pkg;

  typedef enum logic [1:0] {
    RX_IDLE = 2'd0,
    RX_CTRL = 2'd1,
    RX_LEN  = 2'd2,
    RX_DATA = 2'd3
  } rx_state_e;

  typedef enum logic [1:0] {
    KIND_INJECT = 2'd0,
    KIND_BKPT   = 2'd1,
    KIND_BAD    = 2'd2
  } frame_kind_e;

  // index of the last payload bit for a given length bit
  function automatic int unsigned payload_last(input logic len_bit,
                                               input int unsigned long_w,
                                               input int unsigned short_w);
    return len_bit ? long_w - 1 : short_w - 1;
  endfunction

  // control 0 + long = opcode, control 1 + short = breakpoint, else bad
  function automatic frame_kind_e frame_kind(input logic ctrl_bit, input logic len_bit);
    if (!ctrl_bit && len_bit) return KIND_INJECT;
    if (ctrl_bit && !len_bit) return KIND_BKPT;
    return KIND_BAD;
  endfunction

endpackage

// File: rtl/dbgp_sync.sv
module dbgp_sync #(
  parameter int            STAGES  = 2,
  parameter int            W       = 1,
  parameter logic [W-1:0]  RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) pipe[0] <= RST_VAL;
          else     pipe[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) pipe[s] <= RST_VAL;
          else     pipe[s] <= pipe[s-1];
        end
      end
    end
  endgenerate

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/dbgp_frame_rx.sv
module dbgp_frame_rx
  import dbgp_pkg::*;
#(
  parameter int LONG_W  = 32,
  parameter int SHORT_W = 7,
  parameter int CNT_W   = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rise,
  input  logic              din,
  output logic              start_evt,
  output logic              hdr_evt,
  output logic              frame_done,
  output logic              in_frame,
  output logic              rx_ctrl,
  output logic              rx_len,
  output logic [LONG_W-1:0] rx_word
);
  rx_state_e         state;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  last_idx;
  logic [LONG_W-1:0] word_q;

  assign last_idx   = CNT_W'(payload_last(rx_len, LONG_W, SHORT_W));
  assign start_evt  = rise && (state == RX_IDLE) && !din;
  assign hdr_evt    = rise && (state == RX_LEN);
  assign frame_done = rise && (state == RX_DATA) && (cnt == last_idx);
  assign in_frame   = (state != RX_IDLE);
  // completed word including the bit being sampled now
  assign rx_word    = {word_q[LONG_W-2:0], din};

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= RX_IDLE;
      cnt     <= '0;
      rx_ctrl <= 1'b0;
      rx_len  <= 1'b0;
      word_q  <= '0;
    end else if (rise) begin
      unique case (state)
        RX_IDLE: if (!din) begin
          state  <= RX_CTRL;
          word_q <= '0;
        end
        RX_CTRL: begin
          rx_ctrl <= din;
          state   <= RX_LEN;
        end
        RX_LEN: begin
          rx_len <= din;
          cnt    <= '0;
          state  <= RX_DATA;
        end
        RX_DATA: begin
          word_q <= rx_word;
          if (cnt == last_idx) begin
            state <= RX_IDLE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= RX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dbgp_tx_shift.sv
module dbgp_tx_shift #(
  parameter int LONG_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fall,
  input  logic              load,
  input  logic [LONG_W-1:0] data,
  input  logic              clear,
  output logic              dout
);
  logic [LONG_W-1:0] sreg;
  logic              active;

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg   <= '0;
      active <= 1'b0;
      dout   <= 1'b1;
    end else if (clear) begin
      active <= 1'b0;
      dout   <= 1'b1;
    end else if (load) begin
      sreg   <= data;
      active <= 1'b1;
    end else if (fall && active) begin
      dout <= sreg[LONG_W-1];
      sreg <= {sreg[LONG_W-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/dbg_frame_port.sv
module dbg_frame_port
  import dbgp_pkg::*;
#(
  parameter int LONG_W      = 32,
  parameter int SHORT_W     = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sck,
  input  logic              din,
  output logic              dout,
  input  logic              core_in_debug,
  input  logic              core_done,
  input  logic [LONG_W-1:0] core_data,
  output logic [LONG_W-1:0] inject_opcode,
  output logic              inject_valid,
  output logic [SHORT_W-1:0] bkpt_ctrl,
  output logic              busy,
  output logic              frame_err
);
  localparam int CNT_W = $clog2(LONG_W + 1);

  logic [1:0] lines_s;
  logic       sck_s, din_s, sck_q;
  logic       rise, fall;

  dbgp_sync #(.STAGES(SYNC_STAGES), .W(2), .RST_VAL(2'b01)) u_sync (
    .clk(clk), .rst(rst), .d({sck, din}), .q(lines_s)
  );
  assign sck_s = lines_s[1];
  assign din_s = lines_s[0];

  always_ff @(posedge clk) begin
    if (rst) sck_q <= 1'b0;
    else     sck_q <= sck_s;
  end
  assign rise = sck_s && !sck_q;
  assign fall = !sck_s && sck_q;

  logic              start_evt, hdr_evt, frame_done, in_frame;
  logic              rx_ctrl, rx_len;
  logic [LONG_W-1:0] rx_word;

  dbgp_frame_rx #(.LONG_W(LONG_W), .SHORT_W(SHORT_W), .CNT_W(CNT_W)) u_rx (
    .clk(clk), .rst(rst), .rise(rise), .din(din_s),
    .start_evt(start_evt), .hdr_evt(hdr_evt), .frame_done(frame_done),
    .in_frame(in_frame), .rx_ctrl(rx_ctrl), .rx_len(rx_len), .rx_word(rx_word)
  );

  // named events for the checker
  logic        waiting, frame_ignored;
  frame_kind_e kind;
  logic        act_done, inject_go, inject_refused, bkpt_upd, bad_combo, tx_load;

  assign kind           = frame_kind(rx_ctrl, rx_len);
  assign act_done       = frame_done && !frame_ignored;
  assign inject_go      = act_done && (kind == KIND_INJECT) && core_in_debug;
  assign inject_refused = act_done && (kind == KIND_INJECT) && !core_in_debug;
  assign bkpt_upd       = act_done && (kind == KIND_BKPT);
  assign bad_combo      = act_done && (kind == KIND_BAD);
  assign tx_load        = hdr_evt && din_s && !frame_ignored;

  dbgp_tx_shift #(.LONG_W(LONG_W)) u_tx (
    .clk(clk), .rst(rst), .fall(fall), .load(tx_load), .data(core_data),
    .clear(frame_done), .dout(dout)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      waiting       <= 1'b0;
      frame_ignored <= 1'b0;
      frame_err     <= 1'b0;
      bkpt_ctrl     <= '0;
      inject_valid  <= 1'b0;
      inject_opcode <= '0;
    end else begin
      inject_valid <= 1'b0;
      if (waiting && core_done) waiting <= 1'b0;
      if (start_evt) begin
        frame_ignored <= waiting;
        if (waiting) frame_err <= 1'b1;
      end
      if (inject_go) begin
        inject_opcode <= rx_word;
        inject_valid  <= 1'b1;
        waiting       <= 1'b1;
      end
      if (bkpt_upd) bkpt_ctrl <= rx_word[SHORT_W-1:0];
      if (inject_refused || bad_combo) frame_err <= 1'b1;
    end
  end

  assign busy = in_frame || waiting;
endmodule

// File: rtl/dbgp_checker.sv
module dbgp_checker #(
  parameter int SHORT_W = 7
) (
  input logic               clk,
  input logic               rst,
  input logic               dout,
  input logic               busy,
  input logic               inject_valid,
  input logic               core_in_debug,
  input logic               frame_err,
  input logic [SHORT_W-1:0] bkpt_ctrl,
  input logic               bkpt_upd,
  input logic               frame_done,
  input logic               frame_ignored
);
  assert_strobe_single_R3: assert property (@(posedge clk) disable iff (rst)
    inject_valid |=> !inject_valid);

  assert_strobe_busy_R7: assert property (@(posedge clk) disable iff (rst)
    inject_valid |-> busy);

  assert_strobe_debug_R9: assert property (@(posedge clk) disable iff (rst)
    inject_valid |-> $past(core_in_debug));

  assert_dout_idle_R5: assert property (@(posedge clk) disable iff (rst)
    !busy |-> dout);

  assert_err_sticky_R11: assert property (@(posedge clk) disable iff (rst)
    frame_err |=> frame_err);

  assert_bkpt_source_R6: assert property (@(posedge clk) disable iff (rst)
    !$stable(bkpt_ctrl) |-> $past(bkpt_upd));

  assert_ignored_no_strobe_R8: assert property (@(posedge clk) disable iff (rst)
    (frame_done && frame_ignored) |=> !inject_valid);

  assert_ignored_err_R8: assert property (@(posedge clk) disable iff (rst)
    frame_ignored |-> frame_err);
endmodule

bind dbg_frame_port dbgp_checker #(.SHORT_W(SHORT_W)) u_chk (
  .clk(clk), .rst(rst), .dout(dout), .busy(busy), .inject_valid(inject_valid),
  .core_in_debug(core_in_debug), .frame_err(frame_err), .bkpt_ctrl(bkpt_ctrl),
  .bkpt_upd(bkpt_upd), .frame_done(frame_done), .frame_ignored(frame_ignored)
);

// File: tb/dbg_frame_port_test.sv
`timescale 1ns/1ps
module dbg_frame_port_test;
  localparam int HALF = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sck = 1'b0;
  logic        din = 1'b1;
  logic        dout;
  logic        core_in_debug = 1'b1;
  logic        core_done = 1'b0;
  logic [31:0] core_data = '0;
  logic [31:0] inject_opcode;
  logic        inject_valid;
  logic [6:0]  bkpt_ctrl;
  logic        busy;
  logic        frame_err;

  int checks = 0;
  int errors = 0;
  int pulses = 0;
  int wide_pulses = 0;
  logic        prev_valid = 1'b0;
  logic [31:0] last_op = '0;
  logic [31:0] rx_dout;
  logic        busy_mid;

  always #2.5 clk = ~clk;

  dbg_frame_port uut (
    .clk(clk), .rst(rst), .sck(sck), .din(din), .dout(dout),
    .core_in_debug(core_in_debug), .core_done(core_done), .core_data(core_data),
    .inject_opcode(inject_opcode), .inject_valid(inject_valid),
    .bkpt_ctrl(bkpt_ctrl), .busy(busy), .frame_err(frame_err)
  );

  always @(posedge clk) begin
    if (inject_valid) begin
      pulses <= pulses + 1;
      last_op <= inject_opcode;
    end
    if (inject_valid && prev_valid) wide_pulses <= wide_pulses + 1;
    prev_valid <= inject_valid;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic send_bit(input logic b, output logic seen);
    din = b;
    tick(HALF);
    seen = dout;
    sck = 1'b1;
    tick(HALF);
    sck = 1'b0;
  endtask

  task automatic send_frame(input logic c, input logic l, input logic [31:0] pl);
    logic s;
    int n;
    n = l ? 32 : 7;
    rx_dout = '0;
    send_bit(1'b0, s);
    send_bit(c, s);
    din = l;
    tick(HALF);
    busy_mid = busy;
    sck = 1'b1;
    tick(HALF);
    sck = 1'b0;
    for (int i = n - 1; i >= 0; i--) begin
      send_bit(pl[i], s);
      rx_dout = {rx_dout[30:0], s};
    end
    din = 1'b1;
    tick(2 * HALF);
  endtask

  task automatic finish_core();
    core_done = 1'b1;
    tick(1);
    core_done = 1'b0;
    tick(2);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    tick(4);
    rst = 1'b0;
    tick(4);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int p0;
    logic [31:0] pat;
    logic [31:0] cd;
    do_reset();
    // R1 reset state
    chk("R1 dout", {31'd0, dout}, 32'd1);
    chk("R1 busy", {31'd0, busy}, 32'd0);
    chk("R1 err", {31'd0, frame_err}, 32'd0);
    chk("R1 bkpt", {25'd0, bkpt_ctrl}, 32'd0);
    chk("R1 strobe", pulses, 0);

    // R6 / R2: all breakpoint words
    for (int v = 0; v < 128; v++) begin
      p0 = pulses;
      send_frame(1'b1, 1'b0, 32'(v));
      chk("R6 bkpt value", {25'd0, bkpt_ctrl}, 32'(v));
      chk("R6 no strobe", pulses, p0);
      chk("R5 dout high in short frame", rx_dout, 32'h7F);
      chk("R7 busy mid short frame", {31'd0, busy_mid}, 32'd1);
      chk("R7 idle after short frame", {31'd0, busy}, 32'd0);
    end

    // R3 / R4 / R7: walking one opcodes
    for (int b = 0; b < 32; b++) begin
      pat = 32'd1 << b;
      cd  = {pat[15:0], pat[31:16]} ^ 32'hA5C3_0F69;
      core_data = cd;
      p0 = pulses;
      send_frame(1'b0, 1'b1, pat);
      chk("R3 opcode", last_op, pat);
      chk("R3 one strobe", pulses, p0 + 1);
      chk("R4 dout stream", rx_dout, cd);
      chk("R7 busy until done", {31'd0, busy}, 32'd1);
      chk("R5 dout high after frame", {31'd0, dout}, 32'd1);
      finish_core();
      chk("R7 released by core_done", {31'd0, busy}, 32'd0);
    end
    chk("R3 strobe width", wide_pulses, 0);
    chk("R11 no error on good frames", {31'd0, frame_err}, 32'd0);

    // R12: high din clocks while idle start nothing
    for (int k = 0; k < 3; k++) begin
      logic s;
      send_bit(1'b1, s);
    end
    chk("R12 still idle", {31'd0, busy}, 32'd0);
    send_frame(1'b1, 1'b0, 32'h33);
    chk("R12 framing intact", {25'd0, bkpt_ctrl}, 32'h33);

    // R8: frames while opcode pending
    core_data = 32'h1234_5678;
    send_frame(1'b0, 1'b1, 32'hDEAD_BEEF);
    chk("R8 setup opcode", last_op, 32'hDEAD_BEEF);
    p0 = pulses;
    send_frame(1'b1, 1'b0, 32'h55);
    chk("R8 bkpt unchanged", {25'd0, bkpt_ctrl}, 32'h33);
    chk("R8 err set", {31'd0, frame_err}, 32'd1);
    send_frame(1'b0, 1'b1, 32'h0BAD_F00D);
    chk("R8 no strobe", pulses, p0);
    chk("R8 dout stays high", rx_dout, 32'hFFFF_FFFF);
    chk("R8 opcode unchanged", last_op, 32'hDEAD_BEEF);
    finish_core();
    chk("R8 busy released", {31'd0, busy}, 32'd0);
    tick(2);
    chk("R11 err sticky", {31'd0, frame_err}, 32'd1);
    do_reset();
    chk("R11 reset clears err", {31'd0, frame_err}, 32'd0);
    chk("R11 reset clears bkpt", {25'd0, bkpt_ctrl}, 32'd0);

    // R9: not in debug mode
    core_in_debug = 1'b0;
    p0 = pulses;
    send_frame(1'b0, 1'b1, 32'h4C00_0064);
    chk("R9 no strobe", pulses, p0);
    chk("R9 err set", {31'd0, frame_err}, 32'd1);
    chk("R9 not busy", {31'd0, busy}, 32'd0);
    core_in_debug = 1'b1;
    do_reset();

    // R10: mismatched control/length
    send_frame(1'b0, 1'b0, 32'h5A);
    chk("R10 short bad no bkpt", {25'd0, bkpt_ctrl}, 32'd0);
    chk("R10 short bad err", {31'd0, frame_err}, 32'd1);
    do_reset();
    core_data = 32'hC0FF_EE11;
    p0 = pulses;
    send_frame(1'b1, 1'b1, 32'h8765_4321);
    chk("R10 long bad no strobe", pulses, p0);
    chk("R10 long bad dout", rx_dout, 32'hC0FF_EE11);
    chk("R10 long bad err", {31'd0, frame_err}, 32'd1);
    chk("R10 long bad bkpt", {25'd0, bkpt_ctrl}, 32'd0);
    chk("R10 long bad not busy", {31'd0, busy}, 32'd0);
    do_reset();

    // R11: reset in mid-frame
    begin
      logic s;
      send_bit(1'b0, s);
      send_bit(1'b1, s);
      send_bit(1'b0, s);
      send_bit(1'b1, s);
      send_bit(1'b1, s);
      din = 1'b1;
    end
    do_reset();
    chk("R11 mid-frame reset idle", {31'd0, busy}, 32'd0);
    send_frame(1'b1, 1'b0, 32'h2A);
    chk("R11 next frame aligned", {25'd0, bkpt_ctrl}, 32'h2A);
    chk("R11 no err after", {31'd0, frame_err}, 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule